// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation miss by searching a hashed page table held in memory. A requester hands it a 32-bit effective address, together with the access kind: read or write, data side or instruction side, and real access or lookup-only probe. The walker picks the virtual segment identifier from one of sixteen segment registers and forms a hash from that identifier and the page index. It then reads the tag words of one eight-entry page-table group through a simple read port.

If none of the eight tags in that first group matches, it complements the hash and scans a second group with a key whose hash-select bit is set. When a tag matches, it fetches the companion word of that entry and returns the 4 KB physical page number. When both groups miss, or the table base register is zero, it reports a no-translation fault. For a real data-side access, that fault also loads a status word and a fault address and raises a data storage exception pulse.

The walker handles one translation at a time. `busy` is high while a walk is running, and `done` marks the cycle in which the result is valid.

Top module: `hpt_walker`

## Requirements
- R1: Effective address bits 31:28 select one of 16 segment registers. Segment register n occupies bits n*24+23 down to n*24 of `seg_vsid`, and its 24 bits are the virtual segment ID used for hashing and for the key.
- R2: The primary hash is (address bits 27:12, zero-extended) XOR the segment ID, kept to 23 bits. The group address is {tbl_base[31:16], 16'h0} + ((hash & 0x3FF) << 6), plus the table-mask term of R12. Entry i of a group starts at group + 8*i, and its tag is the word at that address.
- R3: The primary key is {1'b1, vsid[23:0], 1'b0, address[27:22]}. Bit 6 is the hash-select bit.
- R4: When all 8 primary tags miss, the secondary hash is the bitwise complement of the primary hash, kept to 23 bits. The secondary key equals the primary key with bit 6 set, and the same 8-entry scan is repeated.
- R5: Tags are read in entry order 0 to 7 and the scan stops at the first match. Only one read is in flight at a time. While `mem_rd_ready` is low, `mem_rd_valid` and `mem_rd_addr` hold.
- R6: On a match at entry i, the walker reads the word at entry + 4. `phys_page` becomes bits 31:12 of that word, `hit` is 1 and `fault` is 0 in the `done` cycle.
- R7: If `tbl_base` is zero at acceptance, the walker issues no memory read. `done` and `fault` are high in the cycle after acceptance.
- R8: When both groups miss, `fault` is reported with `done` after exactly 16 tag reads.
- R9: A fault on a data-side (`req_dside`=1), non-probe request pulses `exc_dsi` with `done`. It also sets `fault_status` to 0x40000000, ORed with 0x02000000 for a write, and sets `fault_addr` to the request address.
- R10: A fault on a probe or an instruction-side request raises no `exc_dsi` and leaves `fault_status` and `fault_addr` unchanged.
- R11: `req_ready` is high only while idle and `busy` is high from acceptance until `done`; a request presented while busy is ignored.
- R12: The table mask is `tbl_base[8:0]`. Hash bits 18:10 ANDed with that mask are placed at group-offset bits 24:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_addr | input | 32 | Effective address |
| req_write | input | 1 | Access is a store |
| req_dside | input | 1 | Data-side access (0 = instruction side) |
| req_probe | input | 1 | Lookup-only probe, never raises an exception |
| seg_vsid | input | 384 | Sixteen 24-bit segment IDs |
| tbl_base | input | 32 | Table origin [31:16] and table mask [8:0] |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid this cycle |
| hit | output | 1 | Translation found |
| fault | output | 1 | No translation |
| phys_page | output | 20 | Physical page number |
| exc_dsi | output | 1 | Data storage exception pulse |
| fault_status | output | 32 | Fault status word |
| fault_addr | output | 32 | Faulting address |

## Verification
The hardest cases to reach are a match in the secondary group and a miss in both groups. To get there, the primary group must hold eight tags that fail, and one of them must differ from the wanted key only in the hash-select bit. The bench fills a sparse memory model at group addresses it computes itself from the hash rules. It then confirms the matching slot through the count and order of the logged read addresses. A run with `mem_rd_ready` toggling shows that the request holds, and a second request held high during a long miss walk shows at the ports that it is ignored.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    localparam int ADDR_W     = 32;
    localparam int VSID_W     = 24;
    localparam int HASH_W     = 23;
    localparam int MASK_W     = 9;
    localparam int NSEG       = 16;
    localparam int SEG_SEL_W  = $clog2(NSEG);
    localparam int PAGE_SHIFT = 12;
    localparam int RPN_W      = ADDR_W - PAGE_SHIFT;
    localparam int GRP_LO_W   = 10;
    localparam int GRP_SHIFT  = 6;
    localparam int ORIGIN_W   = 16;
    localparam int API_W      = 6;

    localparam logic [ADDR_W-1:0] STAT_NOTRANS = 32'h4000_0000;
    localparam logic [ADDR_W-1:0] STAT_STORE   = 32'h0200_0000;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TAG_RD,
        S_TAG_WT,
        S_PTE_RD,
        S_PTE_WT
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0]   ea;
        logic                wr;
        logic                dside;
        logic                probe;
        logic [VSID_W-1:0]   vsid;
        logic [ORIGIN_W-1:0] origin;
        logic [MASK_W-1:0]   mask;
    } walk_ctx_t;

    function automatic logic [HASH_W-1:0] base_hash(
        input logic [ADDR_W-1:0] ea, input logic [VSID_W-1:0] vsid);
        logic [VSID_W-1:0] idx;
        idx = VSID_W'(ea[27:PAGE_SHIFT]);
        return HASH_W'(idx ^ vsid);
    endfunction

    function automatic logic [ADDR_W-1:0] group_offset(
        input logic [HASH_W-1:0] h, input logic [MASK_W-1:0] mask);
        logic [ADDR_W-1:0] lo, hi;
        lo = ADDR_W'(h[GRP_LO_W-1:0]) << GRP_SHIFT;
        hi = ADDR_W'(h[GRP_LO_W+MASK_W-1:GRP_LO_W] & mask) << ORIGIN_W;
        return lo | hi;
    endfunction

    function automatic logic [ADDR_W-1:0] make_key(
        input logic [VSID_W-1:0] vsid, input logic sec, input logic [API_W-1:0] api);
        return {1'b1, vsid, sec, api};
    endfunction
endpackage

// File: rtl/hpt_seg_select.sv
module hpt_seg_select
    import hpt_pkg::*;
#(
    parameter int SEGS = NSEG,
    parameter int VW   = VSID_W,
    localparam int SW  = $clog2(SEGS)
) (
    input  logic [SEGS*VW-1:0] segs,
    input  logic [SW-1:0]      sel,
    output logic [VW-1:0]      vsid
);
    logic [VW-1:0] seg_arr [SEGS];

    for (genvar g = 0; g < SEGS; g++) begin : g_unpack
        assign seg_arr[g] = segs[g*VW +: VW];
    end

    assign vsid = seg_arr[sel];
endmodule

// File: rtl/hpt_hash_unit.sv
module hpt_hash_unit
    import hpt_pkg::*;
(
    input  walk_ctx_t         ctx,
    input  logic              secondary,
    output logic [ADDR_W-1:0] group_addr,
    output logic [ADDR_W-1:0] key
);
    logic [HASH_W-1:0] h_pri;
    logic [HASH_W-1:0] h_sel;

    always_comb begin
        h_pri      = base_hash(ctx.ea, ctx.vsid);
        h_sel      = secondary ? ~h_pri : h_pri;
        group_addr = {ctx.origin, {(ADDR_W-ORIGIN_W){1'b0}}} + group_offset(h_sel, ctx.mask);
        key        = make_key(ctx.vsid, secondary, ctx.ea[27:22]);
    end
endmodule

// File: rtl/hpt_fault_encoder.sv
module hpt_fault_encoder
    import hpt_pkg::*;
(
    input  logic              is_write,
    input  logic              dside,
    input  logic              probe,
    output logic              raise,
    output logic [ADDR_W-1:0] status
);
    always_comb begin
        raise  = dside && !probe;
        status = STAT_NOTRANS | (is_write ? STAT_STORE : '0);
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int GROUP_SLOTS = 8,
    parameter int PTE_BYTES   = 8,
    localparam int SLOT_W     = $clog2(GROUP_SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   req_write,
    input  logic                   req_dside,
    input  logic                   req_probe,
    input  logic [NSEG*VSID_W-1:0] seg_vsid,
    input  logic [ADDR_W-1:0]      tbl_base,
    output logic                   mem_rd_valid,
    input  logic                   mem_rd_ready,
    output logic [ADDR_W-1:0]      mem_rd_addr,
    input  logic                   mem_rsp_valid,
    input  logic [ADDR_W-1:0]      mem_rsp_data,
    output logic                   busy,
    output logic                   done,
    output logic                   hit,
    output logic                   fault,
    output logic [RPN_W-1:0]       phys_page,
    output logic                   exc_dsi,
    output logic [ADDR_W-1:0]      fault_status,
    output logic [ADDR_W-1:0]      fault_addr
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_SLOTS - 1);

    walk_state_e       state;
    walk_ctx_t         ctx;
    logic [SLOT_W-1:0] slot;
    logic              sec_pass;
    logic [VSID_W-1:0] req_vsid;
    logic [ADDR_W-1:0] group_addr;
    logic [ADDR_W-1:0] key;
    logic [ADDR_W-1:0] entry_addr;
    logic              flt_raise;
    logic [ADDR_W-1:0] flt_status;
    logic              flt_wr, flt_ds, flt_pr;
    logic              accept;

    hpt_seg_select u_seg (
        .segs (seg_vsid),
        .sel  (req_addr[ADDR_W-1 -: SEG_SEL_W]),
        .vsid (req_vsid)
    );

    hpt_hash_unit u_hash (
        .ctx        (ctx),
        .secondary  (sec_pass),
        .group_addr (group_addr),
        .key        (key)
    );

    always_comb begin
        if (state == S_IDLE) begin
            flt_wr = req_write;
            flt_ds = req_dside;
            flt_pr = req_probe;
        end else begin
            flt_wr = ctx.wr;
            flt_ds = ctx.dside;
            flt_pr = ctx.probe;
        end
    end

    hpt_fault_encoder u_flt (
        .is_write (flt_wr),
        .dside    (flt_ds),
        .probe    (flt_pr),
        .raise    (flt_raise),
        .status   (flt_status)
    );

    assign req_ready    = (state == S_IDLE);
    assign busy         = (state != S_IDLE);
    assign accept       = req_valid && req_ready;
    assign entry_addr   = group_addr + ADDR_W'(slot) * ADDR_W'(PTE_BYTES);
    assign mem_rd_valid = (state == S_TAG_RD) || (state == S_PTE_RD);
    assign mem_rd_addr  = (state == S_PTE_RD) ? entry_addr + ADDR_W'(4) : entry_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            ctx          <= '0;
            slot         <= '0;
            sec_pass     <= 1'b0;
            done         <= 1'b0;
            hit          <= 1'b0;
            fault        <= 1'b0;
            phys_page    <= '0;
            exc_dsi      <= 1'b0;
            fault_status <= '0;
            fault_addr   <= '0;
        end else begin
            done    <= 1'b0;
            exc_dsi <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        ctx.ea     <= req_addr;
                        ctx.wr     <= req_write;
                        ctx.dside  <= req_dside;
                        ctx.probe  <= req_probe;
                        ctx.vsid   <= req_vsid;
                        ctx.origin <= tbl_base[ADDR_W-1 -: ORIGIN_W];
                        ctx.mask   <= tbl_base[MASK_W-1:0];
                        slot       <= '0;
                        sec_pass   <= 1'b0;
                        hit        <= 1'b0;
                        if (tbl_base == '0) begin
                            done  <= 1'b1;
                            fault <= 1'b1;
                            if (flt_raise) begin
                                exc_dsi      <= 1'b1;
                                fault_status <= flt_status;
                                fault_addr   <= req_addr;
                            end
                        end else begin
                            fault <= 1'b0;
                            state <= S_TAG_RD;
                        end
                    end
                end
                S_TAG_RD: begin
                    if (mem_rd_ready) state <= S_TAG_WT;
                end
                S_TAG_WT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_data == key) begin
                            state <= S_PTE_RD;
                        end else if (slot != LAST_SLOT) begin
                            slot  <= slot + 1'b1;
                            state <= S_TAG_RD;
                        end else if (!sec_pass) begin
                            slot     <= '0;
                            sec_pass <= 1'b1;
                            state    <= S_TAG_RD;
                        end else begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                            fault <= 1'b1;
                            if (flt_raise) begin
                                exc_dsi      <= 1'b1;
                                fault_status <= flt_status;
                                fault_addr   <= ctx.ea;
                            end
                        end
                    end
                end
                S_PTE_RD: begin
                    if (mem_rd_ready) state <= S_PTE_WT;
                end
                S_PTE_WT: begin
                    if (mem_rsp_valid) begin
                        phys_page <= mem_rsp_data[ADDR_W-1:PAGE_SHIFT];
                        hit       <= 1'b1;
                        done      <= 1'b1;
                        state     <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk
    import hpt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              busy,
    input logic              done,
    input logic              hit,
    input logic              fault,
    input logic              exc_dsi,
    input logic [ADDR_W-1:0] fault_status
);
    // R5: a stalled read request holds its address
    a_r5_hold_request: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // R5: every read is word aligned
    a_r5_word_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00);

    // R6: a finished walk reports exactly one of hit or fault
    a_r6_one_outcome: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot({hit, fault}));

    // R9: the exception only accompanies a reported fault
    a_r9_dsi_with_fault: assert property (@(posedge clk) disable iff (rst)
        exc_dsi |-> done && fault && fault_status[30]);

    // R11: no acceptance while busy, and reads only during a walk
    a_r11_ready_idle: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

    a_r11_reads_in_walk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> busy);

    // R11: an accepted request starts a walk or finishes at once
    a_r11_accept_moves: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> busy || done);
endmodule

bind hpt_walker hpt_walker_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .busy         (busy),
    .done         (done),
    .hit          (hit),
    .fault        (fault),
    .exc_dsi      (exc_dsi),
    .fault_status (fault_status)
);

// File: tb/hpt_walker_tb.sv
`timescale 1ns/1ps
module hpt_walker_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic         req_write = 1'b0;
    logic         req_dside = 1'b0;
    logic         req_probe = 1'b0;
    logic [383:0] seg_vsid;
    logic [31:0]  tbl_base = '0;
    logic         mem_rd_valid;
    logic         mem_rd_ready = 1'b1;
    logic [31:0]  mem_rd_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [31:0]  mem_rsp_data = '0;
    logic         busy, done, hit, fault, exc_dsi;
    logic [19:0]  phys_page;
    logic [31:0]  fault_status, fault_addr;

    int checks = 0;
    int fails  = 0;
    int rd_count = 0;
    logic [31:0] rd_log [64];
    logic [31:0] mem [logic [31:0]];
    logic        stall_en = 1'b0;
    logic [23:0] seg [16];

    always #4 clk = ~clk;

    hpt_walker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_dside(req_dside),
        .req_probe(req_probe), .seg_vsid(seg_vsid), .tbl_base(tbl_base),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done), .hit(hit),
        .fault(fault), .phys_page(phys_page), .exc_dsi(exc_dsi),
        .fault_status(fault_status), .fault_addr(fault_addr)
    );

    // memory model: one-cycle response, optional ready toggling
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rd_ready  <= stall_en ? ~mem_rd_ready : 1'b1;
        if (mem_rd_valid && mem_rd_ready) begin
            rd_log[rd_count % 64] <= mem_rd_addr;
            rd_count      <= rd_count + 1;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'h0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [22:0] e_hash(input logic [31:0] ea, input bit sec);
        logic [23:0] v;
        logic [22:0] h;
        v = {8'h0, ea[27:12]} ^ seg[ea[31:28]];
        h = v[22:0];
        return sec ? ~h : h;
    endfunction

    function automatic logic [31:0] e_group(input logic [31:0] ea, input bit sec, input logic [31:0] base);
        logic [22:0] h;
        logic [31:0] off;
        h   = e_hash(ea, sec);
        off = ({22'h0, h[9:0]} << 6) | ({23'h0, h[18:10] & base[8:0]} << 16);
        return {base[31:16], 16'h0} + off;
    endfunction

    function automatic logic [31:0] e_key(input logic [31:0] ea, input bit sec);
        return {1'b1, seg[ea[31:28]], sec, ea[27:22]};
    endfunction

    task automatic walk(input logic [31:0] ea, input bit wr, input bit ds, input bit pr,
                        output int nreads, output int first);
        int c0;
        c0 = rd_count;
        @(negedge clk);
        req_valid = 1'b1; req_addr = ea; req_write = wr; req_dside = ds; req_probe = pr;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        nreads = rd_count - c0;
        first  = c0;
    endtask

    task automatic t_reset();
        chk(req_ready === 1'b1, "R11 reset req_ready", {31'h0, req_ready}, 32'h1);
        chk(busy === 1'b0 && done === 1'b0, "R11 reset busy/done", {30'h0, busy, done}, 32'h0);
        chk(mem_rd_valid === 1'b0, "R5 reset no read", {31'h0, mem_rd_valid}, 32'h0);
        chk(fault_status === 32'h0, "R9 reset status", fault_status, 32'h0);
    endtask

    task automatic t_base_zero();
        int n, f;
        tbl_base = 32'h0;
        walk(32'h1234_5000, 1'b0, 1'b1, 1'b0, n, f);
        chk(fault && !hit, "R7 zero base fault", {30'h0, hit, fault}, 32'h1);
        chk(n == 0, "R7 zero base no reads", n, 0);
        chk(exc_dsi === 1'b1, "R9 zero base dsi", {31'h0, exc_dsi}, 32'h1);
        chk(fault_status == 32'h4000_0000, "R9 read status", fault_status, 32'h4000_0000);
        chk(fault_addr == 32'h1234_5000, "R9 fault addr", fault_addr, 32'h1234_5000);
    endtask

    task automatic t_primary(input int slot_i, input logic [31:0] ea);
        int n, f;
        logic [31:0] g;
        mem.delete();
        tbl_base = 32'h0040_0000;
        g = e_group(ea, 1'b0, tbl_base);
        for (int i = 0; i < slot_i; i++) mem[g + 8*i] = e_key(ea, 1'b1);
        mem[g + 8*slot_i]     = e_key(ea, 1'b0);
        mem[g + 8*slot_i + 4] = 32'hABCDE_19A;
        walk(ea, 1'b0, 1'b1, 1'b0, n, f);
        chk(hit && !fault, "R6 primary hit", {30'h0, hit, fault}, 32'h2);
        chk(phys_page == 20'hABCDE, "R6 phys page", {12'h0, phys_page}, 32'hABCDE);
        chk(n == slot_i + 2, "R5 stop at first match", n, slot_i + 2);
        chk(rd_log[f % 64] == g, "R2 primary group addr", rd_log[f % 64], g);
        chk(rd_log[(f + n - 1) % 64] == g + 8*slot_i + 4, "R6 second word addr",
            rd_log[(f + n - 1) % 64], g + 8*slot_i + 4);
        chk(rd_log[(f + n - 2) % 64] == g + 8*slot_i, "R5 slot order",
            rd_log[(f + n - 2) % 64], g + 8*slot_i);
    endtask

    task automatic t_secondary();
        int n, f;
        logic [31:0] ea, g1, g2;
        mem.delete();
        ea = 32'h3A5C_7000;
        tbl_base = 32'h0040_0000;
        g1 = e_group(ea, 1'b0, tbl_base);
        g2 = e_group(ea, 1'b1, tbl_base);
        // wrong hash-select bit in primary group must not match (R3)
        for (int i = 0; i < 8; i++) mem[g1 + 8*i] = e_key(ea, 1'b1);
        mem[g2 + 24]     = e_key(ea, 1'b1);
        mem[g2 + 24 + 4] = 32'h0F00D_000;
        walk(ea, 1'b0, 1'b1, 1'b0, n, f);
        chk(hit, "R4 secondary hit", {31'h0, hit}, 32'h1);
        chk(phys_page == 20'h0F00D, "R4 secondary page", {12'h0, phys_page}, 32'h0F00D);
        chk(n == 13, "R3 primary key with H set misses", n, 13);
        chk(rd_log[(f + 8) % 64] == g2, "R4 secondary group addr", rd_log[(f + 8) % 64], g2);
    endtask

    task automatic t_double_miss_store();
        int n, f;
        mem.delete();
        tbl_base = 32'h0040_0000;
        walk(32'h5001_3000, 1'b1, 1'b1, 1'b0, n, f);
        chk(fault && !hit, "R8 double miss fault", {30'h0, hit, fault}, 32'h1);
        chk(n == 16, "R8 sixteen reads", n, 16);
        chk(exc_dsi === 1'b1, "R9 store dsi", {31'h0, exc_dsi}, 32'h1);
        chk(fault_status == 32'h4200_0000, "R9 store status", fault_status, 32'h4200_0000);
        chk(fault_addr == 32'h5001_3000, "R9 store addr", fault_addr, 32'h5001_3000);
    endtask

    task automatic t_no_exception(input bit ds, input bit pr, input string tag);
        int n, f;
        mem.delete();
        tbl_base = 32'h0040_0000;
        walk(32'h7777_7000, 1'b0, ds, pr, n, f);
        chk(fault, {tag, " fault"}, {31'h0, fault}, 32'h1);
        chk(exc_dsi === 1'b0, {tag, " no dsi"}, {31'h0, exc_dsi}, 32'h0);
        chk(fault_status == 32'h4200_0000 && fault_addr == 32'h5001_3000,
            {tag, " status kept"}, fault_addr, 32'h5001_3000);
    endtask

    task automatic t_segment();
        int n, f;
        logic [31:0] ea5, ea6, g6;
        mem.delete();
        tbl_base = 32'h0040_0000;
        ea5 = 32'h5012_3000;
        ea6 = 32'h6012_3000;
        mem[e_group(ea5, 1'b0, tbl_base)]     = e_key(ea5, 1'b0);
        mem[e_group(ea5, 1'b0, tbl_base) + 4] = 32'h55555_000;
        walk(ea5, 1'b0, 1'b0, 1'b0, n, f);
        chk(hit && phys_page == 20'h55555, "R1 seg 5 hit", {12'h0, phys_page}, 32'h55555);
        g6 = e_group(ea6, 1'b0, tbl_base);
        walk(ea6, 1'b0, 1'b0, 1'b0, n, f);
        chk(fault, "R1 seg 6 misses", {31'h0, fault}, 32'h1);
        chk(rd_log[f % 64] == g6, "R1 seg 6 group", rd_log[f % 64], g6);
    endtask

    task automatic t_mask();
        int n, f;
        logic [31:0] ea, g;
        mem.delete();
        ea = 32'h00C0_0000;
        tbl_base = 32'h0100_0003;
        g = e_group(ea, 1'b0, tbl_base);
        chk(g != e_group(ea, 1'b0, 32'h0100_0000), "R12 mask term nonzero", g, 32'h0);
        mem[g]     = e_key(ea, 1'b0);
        mem[g + 4] = 32'h12345_000;
        walk(ea, 1'b0, 1'b1, 1'b0, n, f);
        chk(rd_log[f % 64] == g, "R12 masked group addr", rd_log[f % 64], g);
        chk(hit && phys_page == 20'h12345, "R12 masked hit", {12'h0, phys_page}, 32'h12345);
    endtask

    task automatic t_stall();
        stall_en = 1'b1;
        t_primary(2, 32'h2468_A000);
        stall_en = 1'b0;
    endtask

    task automatic t_busy_ignore();
        int c0;
        mem.delete();
        tbl_base = 32'h0040_0000;
        c0 = rd_count;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h9ABC_D000; req_write = 1'b0; req_dside = 1'b1; req_probe = 1'b0;
        @(negedge clk);
        req_addr = 32'h1111_1000;
        for (int i = 0; i < 5; i++) begin
            chk(busy && !req_ready, "R11 busy blocks request", {30'h0, busy, req_ready}, 32'h2);
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(rd_count - c0 == 16, "R11 first walk intact", rd_count - c0, 16);
        chk(fault_addr == 32'h9ABC_D000, "R11 second request ignored", fault_addr, 32'h9ABC_D000);
        repeat (3) @(negedge clk);
        chk(!busy && rd_count - c0 == 16, "R11 no extra walk", rd_count - c0, 16);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            seg[i] = 24'h10_0000 + 24'(i) * 24'h111;
            seg_vsid[i*24 +: 24] = seg[i];
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_base_zero();
        t_primary(0, 32'h0000_1000);
        t_primary(7, 32'hC3F0_2000);
        t_secondary();
        t_double_miss_store();
        t_no_exception(1'b1, 1'b1, "R10 probe");
        t_no_exception(1'b0, 1'b0, "R10 instr side");
        t_segment();
        t_mask();
        t_stall();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule